// File: doc/BRIEF.md
# Shared-Bus Buffered Packet Switch

This block is a low-cost four-port switch. Instead of a crosspoint matrix it moves every word over one internal bus into a small buffer memory and back out again. A round of switching has three phases. In the first, the ports are visited one at a time in ascending index order. Each valid input word is copied into the buffer slot that belongs to its port. In the second, each buffered word's destination field is looked up in a forwarding table to choose an output port. In the third, the buffered words are sent out one at a time in slot order, each on its chosen port.

A port that has no valid word when its turn comes is skipped, and its slot stays empty for the rest of the round. The forwarding table can be rewritten at any time through a small configuration port. Because only one transfer uses the bus in any cycle, total throughput is bounded by the bus and not by the port count.

Top module: `sbsw_switch`

## Requirements
- R1: After reset, no `in_ready` bit and no `out_valid` bit is high. The block stays idle while every `in_valid` bit is low.
- R2: A round starts when any `in_valid` bit is high while the block is idle. Inputs are then accepted one port per cycle in ascending port index. At most one `in_ready` bit is high in any cycle.
- R3: A port whose `in_valid` is low during its gather cycle is skipped. Its slot is empty, and no output word is produced for it in that round.
- R4: Each buffered word leaves on the port held in forwarding-table entry `word[DATA_W-1 -: DEST_W]`, the destination field in the top bits. The word appears unchanged on that port's lane of `out_data`.
- R5: After reset, forwarding-table entry k holds output port k mod NPORTS.
- R6: A cycle with `cfg_we` high stores `cfg_port` into table entry `cfg_id`. Rounds that start afterwards use the new entry. For example, entries 0..3 set to 3,2,1,0 send the words of ports 0,1,2,3 to ports 3,2,1,0.
- R7: Buffered words leave in ascending slot order, including when several go to the same port. At most one `out_valid` bit is high in any cycle.
- R8: While an `out_valid` bit is high and the matching `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: The phases never overlap. No cycle has both an `in_ready` bit and an `out_valid` bit high. The gather of the last port is always followed by the forwarding phase, and the last scatter transfer returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Per-port input word present |
| in_ready | output | NPORTS | Per-port input accepted this cycle |
| in_data | input | NPORTS*DATA_W | Per-port input words, port p at bits p*DATA_W upward |
| out_valid | output | NPORTS | Per-port output word present |
| out_ready | input | NPORTS | Per-port output sink can take a word |
| out_data | output | NPORTS*DATA_W | Per-port output words, lane p at bits p*DATA_W upward, zero when idle |
| cfg_we | input | 1 | Forwarding-table write strobe |
| cfg_id | input | DEST_W | Table entry (destination ID) to write |
| cfg_port | input | $clog2(NPORTS) | Output port stored in the entry |

## Verification
The bench builds the block with NPORTS=4, DATA_W=16 and DEST_W=4. At these values every nonempty combination of valid inputs (fifteen masks) can be swept. Each mask is run under three forwarding maps: the reset map, a reversed map and an all-to-one-port map. Each mask is also paired with one of three output-ready patterns, which exercises skipping, fan-in ordering and back-pressure. The 16-entry table lets destination fields cover every entry, so the reset mapping and the rewritten entries are checked against a model table held in the bench.

// File: rtl/sbsw_pkg.sv
package sbsw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_GATHER  = 2'd1,
        PH_FORWARD = 2'd2,
        PH_SCATTER = 2'd3
    } phase_e;
endpackage

// File: rtl/sbsw_sequencer.sv
module sbsw_sequencer
    import sbsw_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    output phase_e            phase_o,
    output logic [PORT_W-1:0] idx_o
);
    localparam logic [PORT_W-1:0] LAST = PORT_W'(NPORTS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [PORT_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_last;

    always_comb begin
        seq_d   = seq_q;
        at_last = (seq_q.idx == LAST);
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_GATHER;
                    seq_d.idx   = '0;
                end
            end
            PH_GATHER: begin
                if (at_last) begin
                    seq_d.phase = PH_FORWARD;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            PH_FORWARD: begin
                if (at_last) begin
                    seq_d.phase = PH_SCATTER;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: begin
                if (step_i) begin
                    if (at_last) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.idx   = '0;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, idx: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign idx_o   = seq_q.idx;

    // R9: gather of the last port is followed by forwarding
    a_r9_gather_to_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_GATHER && idx_o == LAST) |=> (phase_o == PH_FORWARD));

    // R9: the final scatter transfer returns to idle
    a_r9_scatter_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_SCATTER && idx_o == LAST && step_i) |=> (phase_o == PH_IDLE));
endmodule

// File: rtl/sbsw_slot_mem.sv
module sbsw_slot_mem #(
    parameter int NPORTS = 4,
    parameter int DATA_W = 16,
    parameter int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [PORT_W-1:0] cap_idx_i,
    input  logic              cap_full_i,
    input  logic [DATA_W-1:0] cap_data_i,
    input  logic              route_en_i,
    input  logic [PORT_W-1:0] route_idx_i,
    input  logic [PORT_W-1:0] route_port_i,
    input  logic [PORT_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_full_o,
    output logic [PORT_W-1:0] rd_port_o
);
    typedef struct packed {
        logic [NPORTS-1:0][DATA_W-1:0] data;
        logic [NPORTS-1:0]             full;
        logic [NPORTS-1:0][PORT_W-1:0] port;
    } slots_t;

    slots_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int s = 0; s < NPORTS; s++) begin
            if (cap_en_i && cap_idx_i == PORT_W'(s)) begin
                mem_d.full[s] = cap_full_i;
                if (cap_full_i) begin
                    mem_d.data[s] = cap_data_i;
                end
            end
            if (route_en_i && route_idx_i == PORT_W'(s)) begin
                mem_d.port[s] = route_port_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        rd_full_o = 1'b0;
        rd_port_o = '0;
        for (int s = 0; s < NPORTS; s++) begin
            if (rd_idx_i == PORT_W'(s)) begin
                rd_data_o = mem_q.data[s];
                rd_full_o = mem_q.full[s];
                rd_port_o = mem_q.port[s];
            end
        end
    end

    // R3: a capture without a valid word leaves the slot empty
    a_r3_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && !cap_full_i) |=> !mem_q.full[$past(cap_idx_i)]);
endmodule

// File: rtl/sbsw_fwd_table.sv
module sbsw_fwd_table #(
    parameter int NPORTS = 4,
    parameter int DEST_W = 4,
    parameter int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [DEST_W-1:0] cfg_id_i,
    input  logic [PORT_W-1:0] cfg_port_i,
    input  logic [DEST_W-1:0] lk_id_i,
    output logic [PORT_W-1:0] lk_port_o
);
    localparam int DEPTH = 1 << DEST_W;

    typedef struct packed {
        logic [DEPTH-1:0][PORT_W-1:0] ent;
    } tbl_t;

    function automatic tbl_t reset_map();
        tbl_t t;
        for (int k = 0; k < DEPTH; k++) begin
            t.ent[k] = PORT_W'(k % NPORTS);
        end
        return t;
    endfunction

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we_i) begin
            tbl_d.ent[cfg_id_i] = cfg_port_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= reset_map();
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lk_port_o = tbl_q.ent[lk_id_i];

    // R6: a configuration write lands in the addressed entry
    a_r6_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (tbl_q.ent[$past(cfg_id_i)] == $past(cfg_port_i)));
endmodule

// File: rtl/sbsw_switch.sv
module sbsw_switch
    import sbsw_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DATA_W = 16,
    parameter int DEST_W = 4,
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        in_valid,
    output logic [NPORTS-1:0]        in_ready,
    input  logic [NPORTS*DATA_W-1:0] in_data,
    output logic [NPORTS-1:0]        out_valid,
    input  logic [NPORTS-1:0]        out_ready,
    output logic [NPORTS*DATA_W-1:0] out_data,
    input  logic                     cfg_we,
    input  logic [DEST_W-1:0]        cfg_id,
    input  logic [PORT_W-1:0]        cfg_port
);
    phase_e            phase;
    logic [PORT_W-1:0] idx;
    logic              step;
    logic              cap_full;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_full;
    logic [PORT_W-1:0] rd_port;
    logic [PORT_W-1:0] lk_port;
    logic              sink_ready;
    logic              sel_valid;

    sbsw_sequencer #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (|in_valid),
        .step_i  (step),
        .phase_o (phase),
        .idx_o   (idx)
    );

    // shared bus, input side: the port whose turn it is drives the slot write
    always_comb begin
        cap_full = 1'b0;
        cap_data = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (idx == PORT_W'(i)) begin
                cap_full = in_valid[i];
                cap_data = in_data[i*DATA_W +: DATA_W];
            end
        end
    end

    sbsw_slot_mem #(.NPORTS(NPORTS), .DATA_W(DATA_W), .PORT_W(PORT_W)) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en_i     (phase == PH_GATHER),
        .cap_idx_i    (idx),
        .cap_full_i   (cap_full),
        .cap_data_i   (cap_data),
        .route_en_i   (phase == PH_FORWARD),
        .route_idx_i  (idx),
        .route_port_i (lk_port),
        .rd_idx_i     (idx),
        .rd_data_o    (rd_data),
        .rd_full_o    (rd_full),
        .rd_port_o    (rd_port)
    );

    sbsw_fwd_table #(.NPORTS(NPORTS), .DEST_W(DEST_W), .PORT_W(PORT_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we),
        .cfg_id_i   (cfg_id),
        .cfg_port_i (cfg_port),
        .lk_id_i    (rd_data[DATA_W-1 -: DEST_W]),
        .lk_port_o  (lk_port)
    );

    // shared bus, output side
    always_comb begin
        sink_ready = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (rd_port == PORT_W'(p)) begin
                sink_ready = out_ready[p];
            end
        end
    end

    assign sel_valid = (phase == PH_SCATTER) && rd_full;
    assign step      = !rd_full || sink_ready;

    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
        assign in_ready[p]  = (phase == PH_GATHER) && (idx == PORT_W'(p));
        assign out_valid[p] = sel_valid && (rd_port == PORT_W'(p));
        assign out_data[p*DATA_W +: DATA_W] = out_valid[p] ? rd_data : '0;
    end

    // R2: one input accepted at a time
    a_r2_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R7: one output driven at a time
    a_r7_one_out: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R8: a stalled output holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_data)));

    // R9: gather and scatter never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !((|in_ready) && (|out_valid)));
endmodule

// File: tb/sbsw_switch_bench.sv
module sbsw_switch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int IW = 4;
    localparam int PW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N-1:0]    in_ready;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N-1:0]    out_ready = '0;
    logic [N*DW-1:0] out_data;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_id = '0;
    logic [PW-1:0]   cfg_port = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int model_tbl [1 << IW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sbsw_switch #(.NPORTS(N), .DATA_W(DW), .DEST_W(IW)) u_sbsw_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .cfg_we    (cfg_we),
        .cfg_id    (cfg_id),
        .cfg_port  (cfg_port)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cfg_write(input int id, input int port);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_id   = IW'(id);
        cfg_port = PW'(port);
        model_tbl[id] = port;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one switching round; rmode picks the out_ready pattern
    task automatic run_round(input logic [DW-1:0] w [N], input logic [N-1:0] vmask,
                             input int rmode, input string tag);
        int exp_port [N];
        logic [DW-1:0] exp_data [N];
        int nexp = 0;
        int got = 0;
        int next_in = 0;
        logic [N-1:0] acc_prev = '0;
        bit overlap = 1'b0;
        bit multi = 1'b0;
        int idle_run = 0;
        for (int i = 0; i < N; i++) begin
            if (vmask[i]) begin
                exp_port[nexp] = model_tbl[w[i][DW-1 -: IW]];
                exp_data[nexp] = w[i];
                nexp++;
            end
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) in_data[i*DW +: DW] = w[i];
        in_valid = vmask;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            in_valid = in_valid & ~acc_prev;
            case (rmode)
                0: out_ready = '1;
                1: out_ready = (c % 3 == 0) ? '1 : '0;
                default: out_ready = N'(4'b0101 << (c % 2));
            endcase
            acc_prev = in_valid & in_ready;
            for (int i = 0; i < N; i++) begin
                if (acc_prev[i]) begin
                    while (next_in < N && !vmask[next_in]) next_in++;
                    chk(i == next_in, {tag, " R2 gather order"}, i, next_in);
                    next_in++;
                end
            end
            if ((|in_ready) && (|out_valid)) overlap = 1'b1;
            if ($countones(out_valid) > 1) multi = 1'b1;
            for (int p = 0; p < N; p++) begin
                if (out_valid[p] && out_ready[p]) begin
                    if (got < nexp) begin
                        chk(p == exp_port[got], {tag, " R4 output port"}, p, exp_port[got]);
                        chk(out_data[p*DW +: DW] == exp_data[got], {tag, " R7 slot order/data"},
                            int'(out_data[p*DW +: DW]), int'(exp_data[got]));
                    end
                    got++;
                end
            end
            if (got >= nexp && in_valid == '0) idle_run++;
            if (idle_run > 6) break;
        end
        chk(got == nexp, {tag, " R3 output count"}, got, nexp);
        chk(!overlap, {tag, " R9 no phase overlap"}, int'(overlap), 0);
        chk(!multi, {tag, " R7 single output"}, int'(multi), 0);
        out_ready = '0;
    endtask

    initial begin
        logic [DW-1:0] w [N];
        for (int k = 0; k < (1 << IW); k++) model_tbl[k] = k % N;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset and while no input is valid
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(in_ready == '0, "R1 in_ready idle", int'(in_ready), 0);
            chk(out_valid == '0, "R1 out_valid idle", int'(out_valid), 0);
        end

        // R5: reset map, destinations 4..7 fold onto ports 0..3
        for (int i = 0; i < N; i++) w[i] = DW'(((i + 4) << 12) | (16'h0A0 + i));
        run_round(w, 4'hF, 0, "R5 reset map");

        // R6: reversed mapping 0,1,2,3 -> 3,2,1,0
        for (int k = 0; k < N; k++) cfg_write(k, N - 1 - k);
        for (int i = 0; i < N; i++) w[i] = DW'((i << 12) | (16'h0B0 + i));
        run_round(w, 4'hF, 0, "R6 reversed");

        // sweep: three table maps x all nonempty masks x ready patterns
        for (int t = 0; t < 3; t++) begin
            for (int k = 0; k < (1 << IW); k++) begin
                case (t)
                    0: cfg_write(k, k % N);
                    1: cfg_write(k, N - 1 - (k % N));
                    default: cfg_write(k, 2);
                endcase
            end
            for (int m = 1; m < (1 << N); m++) begin
                for (int i = 0; i < N; i++) begin
                    w[i] = DW'((((i + m + 5 * t) % 16) << 12) | ((t * 256 + m * 16 + i) & 12'hFFF));
                end
                run_round(w, N'(m), m % 3, "sweep R3 R8");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule